// File: doc/BRIEF.md
# Step-Down Converter Fault Supervisor and Sequencer

This block is the digital control layer of a synchronous step-down regulator. It turns a few comparator flags into switching permission, soft-start and soft-stop control, an over-voltage clamp command and a power-good pull-down. Its inputs are the supply-good flag, the enable input, three feedback window flags (below 70 %, above 90 % and above 125 % of target), an over-temperature flag, and a flag that is high when the soft-start ramp has caught up with the feedback voltage. Every interval is set in tenths of a microsecond and turned into clock cycles from the clock frequency parameter. The cycle count is `ceil(tenths * CLK_MHZ / 10)`, with a minimum of one.

Start-up begins only when the supply is good and enable is high. A soft-start window then runs. Switching stays gated until the ramp reaches a pre-biased output, so the output starts from its existing level. Two faults are latched, each with its own response. An under-voltage fault starts a discharge and then holds the output off. An over-voltage fault holds the low-side switch on. Both latches clear only when enable goes low or the supply drops. An over-temperature event also discharges the output, but the block restarts by itself once the flag clears.

Top module: `fsv_supervisor`

## Requirements
- R1: While `por_ok` is low, and from reset, `sw_en`, `ss_active`, `soft_stop` and `ls_force` are 0 and `pg_pulldown` is 1. A low `por_ok` returns the block to idle one cycle later and clears every latch.
- R2: With `por_ok` high, `en` going high makes `ss_active` 1 one cycle later. The soft-start window lasts SS_CYC cycles. After it, `ss_active` is 0 and `sw_en` is 1.
- R3: During soft-start `sw_en` stays 0 until `ramp_meets_fb` is sampled high. It is 1 from the next cycle on.
- R4: The under-voltage filter is masked outside the run phase and for EN_CYC cycles after enable. Once armed, `fb_below_uv` held for UV_CYC consecutive cycles sets `soft_stop` to 1 and `sw_en` to 0 in the next cycle. A shorter burst restarts the count.
- R5: After an under-voltage fault, `soft_stop` stays 1 for STOP_CYC cycles. After that all outputs stay off while `en` stays high. A low `en` clears the latch, and a new start follows when `en` returns high.
- R6: In soft-start, run or discharge, `fb_above_ov` held for OV_CYC consecutive cycles sets `ls_force` to 1 and `sw_en` to 0 in the next cycle. `ls_force` stays 1 after the flag clears, until `en` or `por_ok` goes low.
- R7: `pg_pulldown` is released (0) only in the run phase. That needs at least EN_CYC cycles since enable and `fb_above_pg` held for PG_CYC cycles. It goes to 1 in the same cycle that `fb_below_uv` or `fb_above_ov` is high, and one cycle after `fb_above_pg` falls.
- R8: `ovr_temp` during soft-start or run sets `soft_stop` for STOP_CYC cycles and then holds all outputs off. One cycle after the flag clears the block is idle. One cycle later `ss_active` is 1 again, without any toggle of `en`.
- R9: `en` going low during soft-start or run gives `soft_stop` for STOP_CYC cycles and then idle, with all outputs off.
- R10: When faults trip in the same cycle, over-voltage wins over under-voltage, under-voltage over over-temperature, and over-temperature over shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply above its power-on threshold |
| en | input | 1 | Converter enable |
| fb_below_uv | input | 1 | Feedback below 70 % of target |
| fb_above_pg | input | 1 | Feedback above 90 % of target |
| fb_above_ov | input | 1 | Feedback above 125 % of target |
| ovr_temp | input | 1 | Junction over-temperature flag |
| ramp_meets_fb | input | 1 | Soft-start ramp has reached the feedback level |
| sw_en | output | 1 | Switching allowed |
| ss_active | output | 1 | Soft-start window running |
| soft_stop | output | 1 | Controlled output discharge requested |
| ls_force | output | 1 | Hold the low-side switch fully on |
| pg_pulldown | output | 1 | Power-good pin pulled low when 1 |

## Verification
The supervisor is driven with fault flags held for exactly one cycle less than their filter length, and for exactly the full length. This shows a correct debounce apart from one that is off by one or never restarts. Under-voltage is applied both before and after the enable delay, to show whether the mask follows the enable timer or only the soft-start window. Faults that trip in the same cycle, and an over-temperature flag that clears after an under-voltage latch, tell a correct priority and a correct latch-clear rule apart from an automatic restart. Power-good is probed with one-cycle window violations, which show whether the pull-down reacts at once or a cycle late.

// File: rtl/fsv_pkg.sv
package fsv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SS_HOLD,
    ST_SS_RAMP,
    ST_RUN,
    ST_DISCH,
    ST_UV_LATCH,
    ST_OV_CLAMP,
    ST_OT_HOLD
  } fsv_state_e;

  typedef enum logic [1:0] {
    CZ_SHUT,
    CZ_UV,
    CZ_OT
  } fsv_cause_e;

  // interval in tenths of a microsecond -> clock cycles, rounded up, at least 1
  function automatic int unsigned dus_to_cyc(int unsigned dus, int unsigned mhz);
    int unsigned prod;
    int unsigned res;
    prod = dus * mhz;
    res  = (prod + 9) / 10;
    if (res == 0) res = 1;
    return res;
  endfunction

endpackage

// File: rtl/fsv_satcnt.sv
module fsv_satcnt #(
  parameter int unsigned MAXV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic full
);
  localparam int unsigned W = $clog2(MAXV + 2);
  localparam logic [W-1:0] LIM = W'(MAXV);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign full = (cnt == LIM);
endmodule

// File: rtl/fsv_filter.sv
module fsv_filter #(
  parameter int unsigned LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic flag,
  output logic trip
);
  logic seen;
  logic run_full;

  assign seen = arm && flag;

  fsv_satcnt #(.MAXV(LEN - 1)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!seen),
    .inc   (1'b1),
    .full  (run_full)
  );

  assign trip = seen && run_full;
endmodule

// File: rtl/fsv_seq.sv
module fsv_seq
  import fsv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       en,
  input  logic       ov_trip,
  input  logic       uv_trip,
  input  logic       ot_flag,
  input  logic       ramp_at_fb,
  input  logic       ss_done,
  input  logic       stop_done,
  output fsv_state_e state
);
  fsv_state_e nxt;
  fsv_cause_e cause, ncause, eff;

  always_comb begin
    nxt    = state;
    ncause = cause;
    eff    = en ? cause : CZ_SHUT;
    if (!por_ok) begin
      nxt    = ST_IDLE;
      ncause = CZ_SHUT;
    end else begin
      case (state)
        ST_IDLE: if (en) nxt = ST_SS_HOLD;
        ST_SS_HOLD, ST_SS_RAMP, ST_RUN: begin
          if (ov_trip) nxt = ST_OV_CLAMP;
          else if (uv_trip) begin
            nxt = ST_DISCH; ncause = CZ_UV;
          end else if (ot_flag) begin
            nxt = ST_DISCH; ncause = CZ_OT;
          end else if (!en) begin
            nxt = ST_DISCH; ncause = CZ_SHUT;
          end else if (state != ST_RUN) begin
            if (ss_done) nxt = ST_RUN;
            else if (state == ST_SS_HOLD && ramp_at_fb) nxt = ST_SS_RAMP;
          end
        end
        ST_DISCH: begin
          ncause = eff;
          if (ov_trip) nxt = ST_OV_CLAMP;
          else if (stop_done) begin
            case (eff)
              CZ_SHUT: nxt = ST_IDLE;
              CZ_UV:   nxt = ST_UV_LATCH;
              default: nxt = ST_OT_HOLD;
            endcase
          end
        end
        ST_UV_LATCH, ST_OV_CLAMP: if (!en) nxt = ST_IDLE;
        ST_OT_HOLD: if (!en || !ot_flag) nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cause <= CZ_SHUT;
    end else begin
      state <= nxt;
      cause <= ncause;
    end
  end
endmodule

// File: rtl/fsv_supervisor.sv
module fsv_supervisor
  import fsv_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned SS_DUS   = 10000,
  parameter int unsigned EN_DUS   = 20000,
  parameter int unsigned UV_DUS   = 160,
  parameter int unsigned OV_DUS   = 15,
  parameter int unsigned PG_DUS   = 630,
  parameter int unsigned STOP_DUS = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok,
  input  logic en,
  input  logic fb_below_uv,
  input  logic fb_above_pg,
  input  logic fb_above_ov,
  input  logic ovr_temp,
  input  logic ramp_meets_fb,
  output logic sw_en,
  output logic ss_active,
  output logic soft_stop,
  output logic ls_force,
  output logic pg_pulldown
);
  localparam int unsigned SS_CYC   = dus_to_cyc(SS_DUS, CLK_MHZ);
  localparam int unsigned EN_CYC   = dus_to_cyc(EN_DUS, CLK_MHZ);
  localparam int unsigned UV_CYC   = dus_to_cyc(UV_DUS, CLK_MHZ);
  localparam int unsigned OV_CYC   = dus_to_cyc(OV_DUS, CLK_MHZ);
  localparam int unsigned PG_CYC   = dus_to_cyc(PG_DUS, CLK_MHZ);
  localparam int unsigned STOP_CYC = dus_to_cyc(STOP_DUS, CLK_MHZ);

  fsv_state_e state;

  // named internal events, used by the bound checker
  logic in_ss, in_run, in_disch;
  logic ss_done, stop_done, en_done, pg_full;
  logic uv_arm, ov_arm, uv_trip, ov_trip, pg_qual;

  assign in_ss    = (state == ST_SS_HOLD) || (state == ST_SS_RAMP);
  assign in_run   = (state == ST_RUN);
  assign in_disch = (state == ST_DISCH);
  assign uv_arm   = in_run && en_done;
  assign ov_arm   = in_ss || in_run || in_disch;

  fsv_satcnt #(.MAXV(SS_CYC - 1)) u_ss_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!in_ss), .inc(1'b1), .full(ss_done)
  );

  fsv_satcnt #(.MAXV(STOP_CYC - 1)) u_stop_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!in_disch), .inc(1'b1), .full(stop_done)
  );

  fsv_satcnt #(.MAXV(EN_CYC)) u_en_tmr (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE), .inc(1'b1), .full(en_done)
  );

  fsv_satcnt #(.MAXV(PG_CYC)) u_pg_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!(in_run && fb_above_pg)), .inc(1'b1), .full(pg_full)
  );

  fsv_filter #(.LEN(UV_CYC)) u_uv_flt (
    .clk(clk), .rst_n(rst_n), .arm(uv_arm), .flag(fb_below_uv), .trip(uv_trip)
  );

  fsv_filter #(.LEN(OV_CYC)) u_ov_flt (
    .clk(clk), .rst_n(rst_n), .arm(ov_arm), .flag(fb_above_ov), .trip(ov_trip)
  );

  fsv_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_ok     (por_ok),
    .en         (en),
    .ov_trip    (ov_trip),
    .uv_trip    (uv_trip),
    .ot_flag    (ovr_temp),
    .ramp_at_fb (ramp_meets_fb),
    .ss_done    (ss_done),
    .stop_done  (stop_done),
    .state      (state)
  );

  assign pg_qual     = por_ok && in_run && en_done && pg_full;
  assign sw_en       = in_run || (state == ST_SS_RAMP);
  assign ss_active   = in_ss;
  assign soft_stop   = in_disch;
  assign ls_force    = (state == ST_OV_CLAMP);
  assign pg_pulldown = !(pg_qual && !fb_below_uv && !fb_above_ov);
endmodule

// File: rtl/fsv_supervisor_chk.sv
module fsv_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic por_ok,
  input logic en,
  input logic fb_below_uv,
  input logic fb_above_ov,
  input logic sw_en,
  input logic ss_active,
  input logic soft_stop,
  input logic ls_force,
  input logic pg_pulldown,
  input logic uv_trip,
  input logic ov_trip
);
  // R1
  por_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (!sw_en && !ss_active && !soft_stop && !ls_force && pg_pulldown));

  // R6
  ov_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_trip && por_ok) |=> (ls_force && !sw_en));

  // R6
  ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_force && en && por_ok) |=> ls_force);

  // R4
  uv_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_trip && !ov_trip && por_ok) |=> (soft_stop && !sw_en));

  // R7
  pg_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_pulldown |-> (!fb_below_uv && !fb_above_ov));

  // R7
  pg_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_active |-> pg_pulldown);

  // R3
  sw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(ss_active));
endmodule

bind fsv_supervisor fsv_supervisor_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .por_ok      (por_ok),
  .en          (en),
  .fb_below_uv (fb_below_uv),
  .fb_above_ov (fb_above_ov),
  .sw_en       (sw_en),
  .ss_active   (ss_active),
  .soft_stop   (soft_stop),
  .ls_force    (ls_force),
  .pg_pulldown (pg_pulldown),
  .uv_trip     (uv_trip),
  .ov_trip     (ov_trip)
);

// File: tb/fsv_supervisor_tb_top.sv
module fsv_supervisor_tb_top;
  localparam int MHZ  = 1;
  localparam int SS_D = 200, EN_D = 400, UV_D = 160, OV_D = 15, PG_D = 75, ST_D = 300;

  function automatic int cyc(int d);
    int p;
    p = d * MHZ;
    return (p / 10) + (((p % 10) != 0) ? 1 : 0);
  endfunction

  localparam int SS = cyc(SS_D), EN = cyc(EN_D), UV = cyc(UV_D);
  localparam int OV = cyc(OV_D), PG = cyc(PG_D), STP = cyc(ST_D);

  logic clk = 1'b0;
  logic rst_n, por_ok, en, fb_lo, fb_pg, fb_hi, ot, ramp;
  logic sw_en, ss_active, soft_stop, ls_force, pg_pulldown;

  always #4 clk = ~clk;

  fsv_supervisor #(
    .CLK_MHZ(MHZ), .SS_DUS(SS_D), .EN_DUS(EN_D), .UV_DUS(UV_D),
    .OV_DUS(OV_D), .PG_DUS(PG_D), .STOP_DUS(ST_D)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en(en),
    .fb_below_uv(fb_lo), .fb_above_pg(fb_pg), .fb_above_ov(fb_hi),
    .ovr_temp(ot), .ramp_meets_fb(ramp),
    .sw_en(sw_en), .ss_active(ss_active), .soft_stop(soft_stop),
    .ls_force(ls_force), .pg_pulldown(pg_pulldown)
  );

  int checks = 0, errors = 0, tick = 0, t0 = 0;
  bit done = 0;

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); tick++; end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic outs(string req, int sw, int ss, int st, int lf, int pgl);
    chk({req, " sw_en"}, sw_en, sw);
    chk({req, " ss_active"}, ss_active, ss);
    chk({req, " soft_stop"}, soft_stop, st);
    chk({req, " ls_force"}, ls_force, lf);
    chk({req, " pg_pulldown"}, pg_pulldown, pgl);
  endtask

  task automatic idle_all();
    por_ok = 0; en = 0; fb_lo = 0; fb_pg = 0; fb_hi = 0; ot = 0; ramp = 0;
    step(2);
  endtask

  task automatic start_up();
    ramp = 1; por_ok = 1; en = 1; t0 = tick;
    step(SS + 1);
    outs("R2 run", 1, 0, 0, 0, 1);
  endtask

  task automatic wait_armed();
    while (tick < t0 + EN + 2) step();
  endtask

  task automatic t_reset();
    outs("R1 reset", 0, 0, 0, 0, 1);
    en = 1; step(3);
    outs("R1 por low", 0, 0, 0, 0, 1);
  endtask

  task automatic t_startup();
    idle_all();
    ramp = 0; por_ok = 1; en = 1; t0 = tick;
    step();
    outs("R2 ss start", 0, 1, 0, 0, 1);
    step(5);
    chk("R3 prebias gated", sw_en, 0);
    ramp = 1; step();
    chk("R3 switching after ramp", sw_en, 1);
    while (tick < t0 + SS) step();
    chk("R2 ss last cycle", ss_active, 1);
    step();
    outs("R2 ss end", 1, 0, 0, 0, 1);
  endtask

  task automatic t_uvp();
    idle_all(); start_up();
    fb_lo = 1;
    while (tick < t0 + EN) step();
    fb_lo = 0;
    step(5);
    chk("R4 masked before enable delay", soft_stop, 0);
    fb_lo = 1; step(UV - 1); fb_lo = 0; step(3);
    chk("R4 short burst ignored", soft_stop, 0);
    fb_lo = 1; step(UV - 1);
    chk("R4 not yet", soft_stop, 0);
    step();
    chk("R4 soft_stop", soft_stop, 1);
    chk("R4 sw_en off", sw_en, 0);
    fb_lo = 0;
    step(STP - 1);
    chk("R5 discharge length", soft_stop, 1);
    step();
    outs("R5 latched", 0, 0, 0, 0, 1);
    step(10);
    outs("R5 still latched", 0, 0, 0, 0, 1);
    en = 0; step(); en = 1; step();
    chk("R5 restart after toggle", ss_active, 1);
  endtask

  task automatic t_ovp();
    idle_all(); start_up();
    fb_hi = 1; step(OV - 1); fb_hi = 0; step(2);
    chk("R6 short burst ignored", ls_force, 0);
    fb_hi = 1; step(OV - 1);
    chk("R6 not yet", ls_force, 0);
    step();
    chk("R6 clamp", ls_force, 1);
    chk("R6 sw_en off", sw_en, 0);
    fb_hi = 0; step(10);
    chk("R6 held", ls_force, 1);
    en = 0; step();
    chk("R6 clear on enable low", ls_force, 0);
    en = 1; step(SS + 2);
    fb_hi = 1; step(OV);
    chk("R6 clamp again", ls_force, 1);
    fb_hi = 0; por_ok = 0; step();
    chk("R1 por clears clamp", ls_force, 0);
  endtask

  task automatic t_pg();
    idle_all(); fb_pg = 1; start_up();
    while (tick < t0 + EN) step();
    chk("R7 enable delay holds pg", pg_pulldown, 1);
    step();
    chk("R7 pg released", pg_pulldown, 0);
    fb_hi = 1; #1;
    chk("R7 pg drops on ov", pg_pulldown, 1);
    fb_hi = 0; #1;
    chk("R7 pg back", pg_pulldown, 0);
    fb_lo = 1; #1;
    chk("R7 pg drops on uv", pg_pulldown, 1);
    fb_lo = 0; #1;
    fb_pg = 0; step();
    chk("R7 pg low after fb_pg falls", pg_pulldown, 1);
    fb_pg = 1; step(PG - 1);
    chk("R7 pg delay", pg_pulldown, 1);
    step();
    chk("R7 pg after delay", pg_pulldown, 0);
  endtask

  task automatic t_ot();
    idle_all(); start_up();
    ot = 1; step();
    chk("R8 soft_stop", soft_stop, 1);
    chk("R8 sw_en off", sw_en, 0);
    step(STP - 1);
    chk("R8 discharge length", soft_stop, 1);
    step();
    outs("R8 hold", 0, 0, 0, 0, 1);
    step(5);
    outs("R8 still hold", 0, 0, 0, 0, 1);
    ot = 0; step();
    chk("R8 idle", ss_active, 0);
    step();
    chk("R8 auto restart", ss_active, 1);
  endtask

  task automatic t_shut();
    idle_all(); start_up();
    en = 0; step();
    chk("R9 soft_stop", soft_stop, 1);
    chk("R9 sw_en off", sw_en, 0);
    step(STP - 1);
    chk("R9 discharge length", soft_stop, 1);
    step();
    outs("R9 idle", 0, 0, 0, 0, 1);
    step(5);
    chk("R9 stays idle", ss_active, 0);
  endtask

  task automatic t_prio();
    idle_all(); start_up(); wait_armed();
    fb_lo = 1; step(UV - OV); fb_hi = 1; step(OV);
    chk("R10 ov over uv clamp", ls_force, 1);
    chk("R10 ov over uv no stop", soft_stop, 0);
    idle_all(); start_up(); wait_armed();
    fb_lo = 1; step(UV - 1); ot = 1; step();
    chk("R10 stop", soft_stop, 1);
    fb_lo = 0;
    step(STP);
    ot = 0; step(5);
    chk("R10 uv latch wins over ot", ss_active, 0);
    chk("R10 uv latch off", sw_en, 0);
  endtask

  initial begin
    rst_n = 0; por_ok = 0; en = 0; fb_lo = 0; fb_pg = 0; fb_hi = 0; ot = 0; ramp = 0;
    step(3);
    rst_n = 1;
    step(2);
    t_reset();
    t_startup();
    t_uvp();
    t_ovp();
    t_pg();
    t_ot();
    t_shut();
    t_prio();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule